// File: doc/BRIEF.md
# Micro-TLB with Selective Invalidation

This block is a small, fully associative translation cache held in flip-flops, placed between an address pipeline and a larger two-way set-associative TLB. Each lookup compares the virtual page number and the address-space ID against every stored entry. The hit, the physical frame and the six permission bits come back in the same cycle. On a miss the block raises a refill request toward the main TLB. When the answer arrives, it is staged for one cycle and then written into a chosen slot.

Entries are not dropped when the main TLB evicts its own copy. Because the main TLB can lose a victim while the page is still mapped, the wider associativity of this cache hides conflict thrashing in the two-way array. The entries are cleared only when the main TLB command engine reports a flushing write or an explicit invalidate. A plain victim-replacement write leaves the contents alone. The entry count is a parameter: a data-side instance uses 8 entries and an instruction-side instance uses 4.

Top module: `utlb_cache`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup misses and the round-robin pointer is at slot 0.
- R2: A lookup hits when `lk_valid` is high and some valid entry has an equal page number and either an equal address-space ID or its global flag set. The result appears in the same cycle. On several hits the lowest-index entry supplies `lk_pfn` and `lk_perm`. With no hit, both outputs are zero.
- R3: `rf_req` is high exactly when `lk_valid` is high and the lookup misses. During a request, `rf_vpn` and `rf_asid` equal the lookup's page and ID.
- R4: A response presented with `rsp_valid` in cycle t is written at the clock edge that ends cycle t+1. A lookup in cycle t+1 still misses, and the entry is visible from cycle t+2.
- R5: The permission field `lk_perm[2:0]` holds kernel {read, write, execute} as bits 2, 1 and 0, and `lk_perm[5:3]` holds user {read, write, execute} in the same order. A global response stores `rsp_rwx` in the kernel field and zero in the user field. A non-global response copies `rsp_rwx` into both fields.
- R6: The install slot is chosen by a fixed priority: first the lowest-index valid entry with the same page number and address-space ID, which is overwritten in place; otherwise the lowest-index invalid entry; otherwise the slot under the round-robin pointer. The pointer advances by one, modulo the entry count, only when it is used.
- R7: `mtlb_cmd` is encoded as 2'b00 idle, 2'b01 non-flushing main-TLB write, 2'b10 flushing main-TLB write, and 2'b11 explicit invalidate. Codes 2'b00 and 2'b01 leave every entry unchanged.
- R8: Codes 2'b10 and 2'b11 invalidate every entry at that clock edge. They also discard a response presented in the same cycle or the cycle before, so neither is installed. The round-robin pointer is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space ID |
| lk_hit | output | 1 | Lookup hit (same cycle) |
| lk_pfn | output | PFN_W | Physical frame of the hit entry, zero on miss |
| lk_perm | output | 6 | User rwx [5:3], kernel rwx [2:0], zero on miss |
| rf_req | output | 1 | Refill request to the main TLB |
| rf_vpn | output | VPN_W | Page number to refill |
| rf_asid | output | ASID_W | Address-space ID to refill |
| rsp_valid | input | 1 | Main TLB refill response valid |
| rsp_vpn | input | VPN_W | Response page number |
| rsp_asid | input | ASID_W | Response address-space ID |
| rsp_pfn | input | PFN_W | Response physical frame |
| rsp_rwx | input | 3 | Response read/write/execute bits (2=r, 1=w, 0=x) |
| rsp_global | input | 1 | Response page is global (kernel only) |
| mtlb_cmd | input | 2 | Main TLB command code, see R7 |

## Verification
The bench targets the cycle after a response, when the entry is staged but not yet written. A design that skipped the staging register, or added an extra one, would hit one cycle early or late. It also aims invalidates at a response in the same cycle and in the following cycle; a design that let either response through would leave a live entry after a flush. The bench fills all slots and then refills an already present page: a broken replacement order would evict the wrong page or leave duplicates. Non-flushing writes are issued between lookups of a full cache, and a design that treated them as flushes would turn those hits into misses. Global and user pages are looked up under foreign IDs, and a mix-up in the permission expansion shows up as wrong user bits.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE     = 2'b00,
        CMD_WR_KEEP  = 2'b01,
        CMD_WR_FLUSH = 2'b10,
        CMD_INV_ALL  = 2'b11
    } mtlb_cmd_e;

    localparam int PERM_W = 6;

    // True for commands that wipe the whole micro-TLB.
    function automatic logic cmd_clears(input logic [1:0] code);
        return (code == CMD_WR_FLUSH) || (code == CMD_INV_ALL);
    endfunction

    // Expand three page bits into kernel and user permission fields.
    function automatic logic [PERM_W-1:0] expand_perm(input logic [2:0] rwx,
                                                      input logic       glb);
        logic [PERM_W-1:0] p;
        p[2:0] = rwx;
        p[5:3] = glb ? 3'b000 : rwx;
        return p;
    endfunction

endpackage

// File: rtl/utlb_store.sv
module utlb_store #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 19,
    parameter int PERM_W  = 6,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clr,
    input  logic                            we,
    input  logic [IW-1:0]                   wslot,
    input  logic [VPN_W-1:0]                wvpn,
    input  logic [ASID_W-1:0]               wasid,
    input  logic                            wglb,
    input  logic [PFN_W-1:0]                wpfn,
    input  logic [PERM_W-1:0]               wperm,
    output logic [ENTRIES-1:0]              vld,
    output logic [ENTRIES-1:0][VPN_W-1:0]   vpn,
    output logic [ENTRIES-1:0][ASID_W-1:0]  asid,
    output logic [ENTRIES-1:0]              glb,
    output logic [ENTRIES-1:0][PFN_W-1:0]   pfn,
    output logic [ENTRIES-1:0][PERM_W-1:0]  perm
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic sel;
        assign sel = we && (wslot == IW'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                vld[i] <= 1'b0;
            end else if (sel) begin
                vld[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vpn[i]  <= '0;
                asid[i] <= '0;
                glb[i]  <= 1'b0;
                pfn[i]  <= '0;
                perm[i] <= '0;
            end else if (sel && !clr) begin
                vpn[i]  <= wvpn;
                asid[i] <= wasid;
                glb[i]  <= wglb;
                pfn[i]  <= wpfn;
                perm[i] <= wperm;
            end
        end
    end

endmodule

// File: rtl/utlb_match.sv
module utlb_match #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]              vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0]  asid,
    input  logic [ENTRIES-1:0]              glb,
    input  logic [VPN_W-1:0]                lk_vpn,
    input  logic [ASID_W-1:0]               lk_asid,
    input  logic [VPN_W-1:0]                in_vpn,
    input  logic [ASID_W-1:0]               in_asid,
    output logic [ENTRIES-1:0]              hit_vec,
    output logic [ENTRIES-1:0]              same_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic page_eq, id_eq, ins_page_eq, ins_id_eq;
        assign page_eq     = (vpn[i] == lk_vpn);
        assign id_eq       = (asid[i] == lk_asid);
        assign ins_page_eq = (vpn[i] == in_vpn);
        assign ins_id_eq   = (asid[i] == in_asid);
        assign hit_vec[i]  = vld[i] && page_eq && (id_eq || glb[i]);
        assign same_vec[i] = vld[i] && ins_page_eq && ins_id_eq;
    end

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [ENTRIES-1:0] vld,
    input  logic [ENTRIES-1:0] same_vec,
    output logic [IW-1:0]      slot
);

    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [IW-1:0] rr_q;
    logic [IW-1:0] same_idx, free_idx;
    logic          any_same, any_free, take_rr;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        any_same = 1'b0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same_vec[i]) begin
                same_idx = IW'(i);
                any_same = 1'b1;
            end
            if (!vld[i]) begin
                free_idx = IW'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        take_rr = 1'b0;
        if (any_same) begin
            slot = same_idx;
        end else if (any_free) begin
            slot = free_idx;
        end else begin
            slot    = rr_q;
            take_rr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (commit && take_rr) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 19,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [5:0]        lk_perm,
    output logic              rf_req,
    output logic [VPN_W-1:0]  rf_vpn,
    output logic [ASID_W-1:0] rf_asid,
    input  logic              rsp_valid,
    input  logic [VPN_W-1:0]  rsp_vpn,
    input  logic [ASID_W-1:0] rsp_asid,
    input  logic [PFN_W-1:0]  rsp_pfn,
    input  logic [2:0]        rsp_rwx,
    input  logic              rsp_global,
    input  logic [1:0]        mtlb_cmd
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glb;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } fill_t;

    logic  clr;
    logic  stg_vld;
    fill_t stg;
    logic  ins_en;

    logic [ENTRIES-1:0]              ent_vld;
    logic [ENTRIES-1:0][VPN_W-1:0]   ent_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0]  ent_asid;
    logic [ENTRIES-1:0]              ent_glb;
    logic [ENTRIES-1:0][PFN_W-1:0]   ent_pfn;
    logic [ENTRIES-1:0][PERM_W-1:0]  ent_perm;
    logic [ENTRIES-1:0]              hit_vec, same_vec;
    logic [IW-1:0]                   slot;

    assign clr = cmd_clears(mtlb_cmd);

    // One-cycle staging of the main TLB response.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stg_vld <= 1'b0;
        end else begin
            stg_vld <= rsp_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else if (rsp_valid) begin
            stg.vpn  <= rsp_vpn;
            stg.asid <= rsp_asid;
            stg.glb  <= rsp_global;
            stg.pfn  <= rsp_pfn;
            stg.perm <= expand_perm(rsp_rwx, rsp_global);
        end
    end

    assign ins_en = stg_vld && !clr;

    utlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W),
        .PFN_W(PFN_W), .PERM_W(PERM_W)
    ) u_store (
        .clk(clk), .rst(rst), .clr(clr), .we(ins_en), .wslot(slot),
        .wvpn(stg.vpn), .wasid(stg.asid), .wglb(stg.glb),
        .wpfn(stg.pfn), .wperm(stg.perm),
        .vld(ent_vld), .vpn(ent_vpn), .asid(ent_asid), .glb(ent_glb),
        .pfn(ent_pfn), .perm(ent_perm)
    );

    utlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)
    ) u_match (
        .vld(ent_vld), .vpn(ent_vpn), .asid(ent_asid), .glb(ent_glb),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .in_vpn(stg.vpn), .in_asid(stg.asid),
        .hit_vec(hit_vec), .same_vec(same_vec)
    );

    utlb_victim #(
        .ENTRIES(ENTRIES)
    ) u_victim (
        .clk(clk), .rst(rst), .commit(ins_en),
        .vld(ent_vld), .same_vec(same_vec), .slot(slot)
    );

    // Lowest-index hit drives the result.
    always_comb begin
        lk_hit  = 1'b0;
        lk_pfn  = '0;
        lk_perm = '0;
        if (lk_valid) begin
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (hit_vec[i]) begin
                    lk_hit  = 1'b1;
                    lk_pfn  = ent_pfn[i];
                    lk_perm = ent_perm[i];
                end
            end
        end
    end

    assign rf_req  = lk_valid && !lk_hit;
    assign rf_vpn  = lk_vpn;
    assign rf_asid = lk_asid;

endmodule

// File: rtl/utlb_checker.sv
module utlb_checker
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PFN_W   = 19
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         mtlb_cmd,
    input logic               rsp_valid,
    input logic               lk_hit,
    input logic [PFN_W-1:0]   lk_pfn,
    input logic [5:0]         lk_perm,
    input logic [ENTRIES-1:0] ent_vld
);

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pfn == '0) && (lk_perm == '0)); // R2

    AST_USER_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && lk_perm[5:3] != 3'b000) |-> (lk_perm[5:3] == lk_perm[2:0])); // R5

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cmd_clears(mtlb_cmd) |=> (ent_vld == '0)); // R8

    AST_CLEAR_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        cmd_clears(mtlb_cmd) |=> !lk_hit); // R8

    AST_INSTALL_LANDS: assert property (@(posedge clk) disable iff (rst)
        ($past(rsp_valid, 2) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3)
         && !cmd_clears($past(mtlb_cmd, 1)) && !cmd_clears($past(mtlb_cmd, 2)))
        |-> (ent_vld != '0)); // R4

endmodule

bind utlb_cache utlb_checker #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
    .clk(clk), .rst(rst), .mtlb_cmd(mtlb_cmd), .rsp_valid(rsp_valid),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm), .ent_vld(ent_vld)
);

// File: tb/sim_utlb_cache.sv
module sim_utlb_cache;
    import utlb_pkg::*;

    localparam int N  = 8;
    localparam int VW = 19;
    localparam int AW = 8;
    localparam int PW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_pfn;
    logic [5:0]    lk_perm;
    logic          rf_req;
    logic [VW-1:0] rf_vpn;
    logic [AW-1:0] rf_asid;
    logic          rsp_valid = 1'b0;
    logic [VW-1:0] rsp_vpn = '0;
    logic [AW-1:0] rsp_asid = '0;
    logic [PW-1:0] rsp_pfn = '0;
    logic [2:0]    rsp_rwx = '0;
    logic          rsp_global = 1'b0;
    logic [1:0]    mtlb_cmd = 2'b00;

    always #5 clk = ~clk;

    utlb_cache #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) u0 (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
        .rf_req(rf_req), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rsp_valid(rsp_valid), .rsp_vpn(rsp_vpn), .rsp_asid(rsp_asid),
        .rsp_pfn(rsp_pfn), .rsp_rwx(rsp_rwx), .rsp_global(rsp_global),
        .mtlb_cmd(mtlb_cmd)
    );

    // Behavioural reference state
    bit            m_v[N];
    logic [VW-1:0] m_vpn[N];
    logic [AW-1:0] m_asid[N];
    bit            m_g[N];
    logic [PW-1:0] m_pfn[N];
    logic [5:0]    m_perm[N];
    bit            s_v;
    logic [VW-1:0] s_vpn;
    logic [AW-1:0] s_asid;
    bit            s_g;
    logic [PW-1:0] s_pfn;
    logic [2:0]    s_rwx;
    int            rr;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        s_v = 1'b0;
        rr  = 0;
    endtask

    task automatic model_install();
        int slot = -1;
        for (int i = 0; i < N; i++)
            if (slot < 0 && m_v[i] && m_vpn[i] == s_vpn && m_asid[i] == s_asid) slot = i;
        if (slot < 0)
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin
            slot = rr;
            rr = (rr + 1) % N;
        end
        m_v[slot]    = 1'b1;
        m_vpn[slot]  = s_vpn;
        m_asid[slot] = s_asid;
        m_g[slot]    = s_g;
        m_pfn[slot]  = s_pfn;
        m_perm[slot] = s_g ? {3'b000, s_rwx} : {s_rwx, s_rwx};
    endtask

    task automatic model_edge();
        if (rst) begin
            model_reset();
        end else if (mtlb_cmd == 2'b10 || mtlb_cmd == 2'b11) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            s_v = 1'b0;
        end else begin
            if (s_v) model_install();
            s_v = rsp_valid;
            if (rsp_valid) begin
                s_vpn = rsp_vpn; s_asid = rsp_asid; s_g = rsp_global;
                s_pfn = rsp_pfn; s_rwx = rsp_rwx;
            end
        end
    endtask

    task automatic compare(input string tag);
        bit            e_hit = 1'b0;
        logic [PW-1:0] e_pfn = '0;
        logic [5:0]    e_perm = '0;
        bit            e_req;
        bit            bad;
        if (lk_valid)
            for (int i = 0; i < N; i++)
                if (!e_hit && m_v[i] && m_vpn[i] == lk_vpn && (m_asid[i] == lk_asid || m_g[i])) begin
                    e_hit = 1'b1; e_pfn = m_pfn[i]; e_perm = m_perm[i];
                end
        e_req = lk_valid && !e_hit;
        bad = (lk_hit !== e_hit) || (lk_pfn !== e_pfn) || (lk_perm !== e_perm) || (rf_req !== e_req);
        if (e_req && (rf_vpn !== lk_vpn || rf_asid !== lk_asid)) bad = 1'b1;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s: hit=%0b exp %0b pfn=%h exp %h perm=%b exp %b req=%0b exp %0b",
                     tag, lk_hit, e_hit, lk_pfn, e_pfn, lk_perm, e_perm, rf_req, e_req);
        end
    endtask

    task automatic step(input bit lv, input int vpn, input int asid,
                        input bit rv, input int rvpn, input int rasid, input int rpfn,
                        input int rwx, input bit rg, input int cmd, input string tag);
        @(negedge clk);
        lk_valid = lv; lk_vpn = VW'(vpn); lk_asid = AW'(asid);
        rsp_valid = rv; rsp_vpn = VW'(rvpn); rsp_asid = AW'(rasid); rsp_pfn = PW'(rpfn);
        rsp_rwx = 3'(rwx); rsp_global = rg; mtlb_cmd = 2'(cmd);
        #1;
        compare(tag);
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic lookup(input int vpn, input int asid, input string tag);
        step(1, vpn, asid, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic refill(input int vpn, input int asid, input int pfn, input int rwx,
                          input bit g, input string tag);
        step(0, 0, 0, 1, vpn, asid, pfn, rwx, g, 0, tag);
        lookup(vpn, asid, "R4 staged entry not yet visible");
    endtask

    initial begin
        model_reset();
        repeat (3) step(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, "R1 during reset");
        @(negedge clk); rst = 1'b0;
        lookup(5, 1, "R1 empty after reset");
        lookup(0, 0, "R3 miss request echo");

        for (int i = 0; i < N; i++)
            refill(16 + i, 3, 100 + i, i, (i == 2 || i == 5), "R5 fill");
        for (int i = 0; i < N; i++) lookup(16 + i, 3, "R2 own id hit");
        for (int i = 0; i < N; i++) lookup(16 + i, 9, "R2 foreign id, global only");
        lookup(30, 3, "R3 miss on unknown page");

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 non-flushing write");
        step(1, 17, 3, 0, 0, 0, 0, 0, 0, 1, "R7 lookup during keep write");
        for (int i = 0; i < N; i++) lookup(16 + i, 3, "R7 entries kept");

        refill(40, 3, 200, 7, 0, "R6 round robin slot 0");
        lookup(16, 3, "R6 slot 0 evicted");
        lookup(40, 3, "R6 new page hit");
        refill(41, 3, 201, 1, 0, "R6 round robin slot 1");
        lookup(17, 3, "R6 slot 1 evicted");
        refill(40, 3, 222, 4, 1, "R6 same tag in place");
        lookup(40, 3, "R6 updated entry");
        lookup(18, 3, "R6 slot 2 untouched");

        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R8 invalidate");
        for (int i = 0; i < N; i++) lookup(16 + i, 3, "R8 cleared by invalidate");
        refill(50, 4, 300, 5, 0, "R6 first free after clear");
        lookup(50, 4, "R8 refill after clear");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 2, "R8 flushing write");
        lookup(50, 4, "R8 cleared by flushing write");

        step(0, 0, 0, 1, 60, 4, 1, 3, 0, 3, "R8 response with invalidate");
        lookup(60, 4, "R8 same-cycle response dropped");
        lookup(60, 4, "R8 same-cycle response stays dropped");
        step(0, 0, 0, 1, 61, 4, 2, 3, 0, 0, "R8 response");
        step(1, 61, 4, 0, 0, 0, 0, 0, 0, 2, "R8 flush next cycle");
        lookup(61, 4, "R8 staged response dropped");

        for (int n = 0; n < 3000; n++) begin
            int c = $urandom_range(0, 99);
            int cmd = (c < 2) ? 3 : (c < 3) ? 2 : (c < 13) ? 1 : 0;
            step($urandom_range(0, 3) != 0, $urandom_range(0, 11), $urandom_range(0, 2),
                 $urandom_range(0, 9) < 3, $urandom_range(0, 11), $urandom_range(0, 2),
                 $urandom, $urandom_range(0, 7), $urandom_range(0, 3) == 0, cmd,
                 "R2 R6 R8 random mix");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule